// File: doc/BRIEF.md
# AES32 Byte-Slice Round Unit

This unit performs one AES step on a single byte for a 32-bit scalar crypto datapath. One byte lane of the second operand is chosen by a 2-bit lane select. That byte goes through the forward or the inverse S-box. It is then either widened to a full mix-column contribution word or left as a zero-extended byte. The word is rotated back into the lane the byte came from and XORed into the first operand. Four such operations, one per lane, build one column of an AES round from a running accumulator.

The unit accepts work on a valid/ready input handshake and holds its answer in one output register behind a valid/ready output handshake. Latency is one cycle. The 32-bit answer is sign-extended to the XLEN parameter (32 or 64). The S-boxes are not stored tables: they are computed from a GF(2^8) inversion plus the affine map or its inverse.

Top module: `aes32_slice_unit`

## Requirements
- R1: The byte processed is bits [8*in_bsel+7 : 8*in_bsel] of in_rs2 (lane 0 is the least significant byte).
- R2: When in_op[1] is 0 (encrypt), the byte is replaced by its forward AES S-box value (for example 0x00 becomes 0x63 and 0x53 becomes 0xED).
- R3: When in_op[1] is 1 (decrypt), the byte is replaced by its inverse AES S-box value (for example 0x63 becomes 0x00).
- R4: For in_op = 2'b01 (encrypt with mix), the word built from substituted byte s is, from byte 3 down to byte 0, {3·s, s, s, 2·s}. Products are in GF(2^8) with the reduction constant 0x1B.
- R5: For in_op = 2'b11 (decrypt with mix), the word is, from byte 3 down to byte 0, {0x0B·s, 0x0D·s, 0x09·s, 0x0E·s}.
- R6: For in_op[0] = 0 (no mix), the word is the substituted byte zero-extended to 32 bits.
- R7: The word is rotated left by 8*in_bsel bits and XORed with in_rs1. Without mix, this leaves every byte of in_rs1 outside the selected lane unchanged.
- R8: out_result bits above 31 all equal bit 31 of the 32-bit answer.
- R9: An operation accepted at a clock edge (in_valid and in_ready both high) is presented with out_valid high after that edge.
- R10: in_ready is high exactly when out_valid is low or out_ready is high. While out_valid is high and out_ready is low, out_result and out_valid hold.
- R11: A synchronous active-high rst clears out_valid at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can take a request this cycle |
| in_rs1 | input | 32 | Accumulator operand |
| in_rs2 | input | 32 | State operand holding the byte to process |
| in_bsel | input | 2 | Byte lane select |
| in_op | input | 2 | bit 1: decrypt; bit 0: apply column mix |
| out_valid | output | 1 | Result register holds an unconsumed result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | XLEN | Sign-extended result |

## Verification
All 256 byte values are swept through each of the four variants, so every S-box entry and every constant product is seen. An error in the inversion or the affine constants, or a swapped forward/inverse mix order, shows up as a wrong value in some lane. The lane select is swept against operands with distinct bytes and a random accumulator. A wrong rotation direction or a lane picked from the wrong end leaves the substituted byte in the wrong lane or corrupts neighbours of in_rs1. Accumulators with bit 31 set expose a missing sign extension. Random backpressure, including a reset arriving while a result is stalled, targets handshakes that drop, duplicate or change a held result.

// File: rtl/aes32_slice_pkg.sv
package aes32_slice_pkg;
  localparam int WORD_W = 32;
  localparam int LANE_W = 8;
  localparam int LANES  = WORD_W / LANE_W;
  localparam int SEL_W  = $clog2(LANES);

  typedef enum logic [1:0] {
    OP_ENC     = 2'b00,
    OP_ENC_MIX = 2'b01,
    OP_DEC     = 2'b10,
    OP_DEC_MIX = 2'b11
  } slice_op_e;

  function automatic logic [7:0] gf_x2(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  // product with a small constant: one xtime stage per constant bit
  function automatic logic [7:0] gf_kmul(input logic [7:0] a, input logic [3:0] k);
    logic [7:0] acc, t;
    acc = '0;
    t   = a;
    for (int i = 0; i < 4; i++) begin
      if (k[i]) acc = acc ^ t;
      t = gf_x2(t);
    end
    return acc;
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc, t;
    acc = '0;
    t   = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ t;
      t = gf_x2(t);
    end
    return acc;
  endfunction

  // a^254 gives the multiplicative inverse, with 0 mapped to 0
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] r, base;
    logic [7:0] e;
    r    = 8'h01;
    base = a;
    e    = 8'd254;
    for (int i = 0; i < 8; i++) begin
      if (e[i]) r = gf_mul(r, base);
      base = gf_mul(base, base);
    end
    return r;
  endfunction

  function automatic logic [7:0] rol8(input logic [7:0] a, input int n);
    return (a << n) | (a >> (8 - n));
  endfunction

  function automatic logic [7:0] affine_fwd(input logic [7:0] a);
    return a ^ rol8(a, 1) ^ rol8(a, 2) ^ rol8(a, 3) ^ rol8(a, 4) ^ 8'h63;
  endfunction

  function automatic logic [7:0] affine_inv(input logic [7:0] a);
    return rol8(a, 1) ^ rol8(a, 3) ^ rol8(a, 6) ^ 8'h05;
  endfunction
endpackage

// File: rtl/aes32_sbox.sv
module aes32_sbox
  import aes32_slice_pkg::*;
(
  input  logic       inv,
  input  logic [7:0] din,
  output logic [7:0] dout
);
  logic [7:0] pre, recip;

  // one shared inverter; the affine maps sit on either side of it
  always_comb begin
    pre   = inv ? affine_inv(din) : din;
    recip = gf_inv(pre);
    dout  = inv ? recip : affine_fwd(recip);
  end
endmodule

// File: rtl/aes32_mix_word.sv
module aes32_mix_word
  import aes32_slice_pkg::*;
(
  input  logic              inv,
  input  logic              mix_en,
  input  logic [7:0]        s,
  output logic [WORD_W-1:0] word
);
  always_comb begin
    if (!mix_en)
      word = {{(WORD_W-LANE_W){1'b0}}, s};
    else if (inv)
      word = {gf_kmul(s, 4'hb), gf_kmul(s, 4'hd), gf_kmul(s, 4'h9), gf_kmul(s, 4'he)};
    else
      word = {gf_kmul(s, 4'h3), s, s, gf_kmul(s, 4'h2)};
  end
endmodule

// File: rtl/aes32_lane_ops.sv
module aes32_lane_ops
  import aes32_slice_pkg::*;
(
  input  logic [SEL_W-1:0]  sel,
  input  logic [WORD_W-1:0] src,
  input  logic [WORD_W-1:0] word,
  output logic [LANE_W-1:0] picked,
  output logic [WORD_W-1:0] rotated
);
  assign picked = src[sel*LANE_W +: LANE_W];

  // output lane j takes word lane (j - sel) mod LANES: a left rotation by whole lanes
  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [SEL_W-1:0] from_lane;
    assign from_lane = SEL_W'(j) - sel;
    assign rotated[j*LANE_W +: LANE_W] = word[from_lane*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/aes32_slice_unit.sv
module aes32_slice_unit
  import aes32_slice_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [31:0]      in_rs1,
  input  logic [31:0]      in_rs2,
  input  logic [1:0]       in_bsel,
  input  logic [1:0]       in_op,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [XLEN-1:0]  out_result
);
  localparam int EXT_W = XLEN - WORD_W;

  slice_op_e         op;
  logic [LANE_W-1:0] byte_in, byte_sub;
  logic [WORD_W-1:0] mix_w, rot_w, ans;
  logic [XLEN-1:0]   ans_ext;
  logic              take;

  assign op = slice_op_e'(in_op);

  aes32_lane_ops lanes_i (
    .sel     (in_bsel),
    .src     (in_rs2),
    .word    (mix_w),
    .picked  (byte_in),
    .rotated (rot_w)
  );

  aes32_sbox sbox_i (
    .inv  (op == OP_DEC || op == OP_DEC_MIX),
    .din  (byte_in),
    .dout (byte_sub)
  );

  aes32_mix_word mix_i (
    .inv    (op == OP_DEC_MIX),
    .mix_en (op == OP_ENC_MIX || op == OP_DEC_MIX),
    .s      (byte_sub),
    .word   (mix_w)
  );

  assign ans = rot_w ^ in_rs1;

  if (EXT_W > 0) begin : g_sext
    assign ans_ext = {{EXT_W{ans[WORD_W-1]}}, ans};
  end else begin : g_nosext
    assign ans_ext = ans;
  end

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (take) out_result <= ans_ext;
  end
endmodule

// File: rtl/aes32_slice_chk.sv
module aes32_slice_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic            in_ready,
  input logic [31:0]     in_rs1,
  input logic [1:0]      in_bsel,
  input logic [1:0]      in_op,
  input logic            out_valid,
  input logic            out_ready,
  input logic [XLEN-1:0] out_result
);
  assert_reset_clears_R11: assert property (@(posedge clk) rst |=> !out_valid);

  assert_accept_latency_R9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);

  assert_ready_when_empty_R10: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> in_ready);

  assert_hold_on_stall_R10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result)));

  assert_lane_only_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && !in_op[0]) |=>
    (((out_result[31:0] ^ $past(in_rs1)) & ~(32'h0000_00ff << {$past(in_bsel), 3'b000})) == 32'h0));

  if (XLEN > 32) begin : g_sext_chk
    assert_sign_ext_R8: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (out_result[XLEN-1:32] == {(XLEN-32){out_result[31]}}));
  end
endmodule

bind aes32_slice_unit aes32_slice_chk #(.XLEN(XLEN)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_rs1     (in_rs1),
  .in_bsel    (in_bsel),
  .in_op      (in_op),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_result (out_result)
);

// File: tb/aes32_slice_unit_tb_top.sv
`timescale 1ns/1ps
module aes32_slice_unit_tb_top;
  localparam int XLEN = 64;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            in_valid = 1'b0;
  logic            in_ready;
  logic [31:0]     in_rs1 = '0;
  logic [31:0]     in_rs2 = '0;
  logic [1:0]      in_bsel = '0;
  logic [1:0]      in_op = '0;
  logic            out_valid;
  logic            out_ready = 1'b1;
  logic [XLEN-1:0] out_result;

  always #2.5 clk = ~clk;

  aes32_slice_unit #(.XLEN(XLEN)) dut_i (.*);

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  byte unsigned fwd_tab [256];
  byte unsigned inv_tab [256];

  // reference model state: one result slot
  bit              m_valid = 0;
  logic [XLEN-1:0] m_res   = '0;
  string           m_tag   = "R9";

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic byte unsigned xt(input byte unsigned a);
    return byte'((a << 1) ^ ((a & 8'h80) != 0 ? 8'h1b : 8'h00));
  endfunction

  function automatic byte unsigned gm(input byte unsigned a, input int k);
    byte unsigned r = 0;
    byte unsigned t = a;
    for (int i = 0; i < 4; i++) begin
      if (k[i]) r = r ^ t;
      t = xt(t);
    end
    return r;
  endfunction

  function automatic byte unsigned r8(input byte unsigned a, input int n);
    return byte'((a << n) | (a >> (8 - n)));
  endfunction

  // builds the tables by walking powers of the generator 3 and of its inverse
  task automatic build_tables();
    byte unsigned p = 1, q = 1, x;
    do begin
      p = p ^ xt(p);
      q = q ^ byte'(q << 1);
      q = q ^ byte'(q << 2);
      q = q ^ byte'(q << 4);
      if ((q & 8'h80) != 0) q = q ^ 8'h09;
      x = q ^ r8(q, 1) ^ r8(q, 2) ^ r8(q, 3) ^ r8(q, 4);
      fwd_tab[p] = x ^ 8'h63;
    end while (p != 1);
    fwd_tab[0] = 8'h63;
    for (int i = 0; i < 256; i++) inv_tab[fwd_tab[i]] = byte'(i);
  endtask

  function automatic logic [XLEN-1:0] model(input logic [31:0] a, input logic [31:0] b,
                                            input logic [1:0] sel, input logic [1:0] op);
    logic [63:0] w, rot;
    logic [31:0] r;
    byte unsigned by, s;
    int sh;
    sh = 8 * sel;
    by = byte'(b >> sh);
    s  = op[1] ? inv_tab[by] : fwd_tab[by];
    if (!op[0])     w = {56'h0, s};
    else if (op[1]) w = {32'h0, gm(s, 11), gm(s, 13), gm(s, 9), gm(s, 14)};
    else            w = {32'h0, gm(s, 3), s, s, gm(s, 2)};
    rot = (w << sh) | (w >> (32 - sh));
    r = a ^ rot[31:0];
    return {{(XLEN-32){r[31]}}, r};
  endfunction

  // one clock: compare outputs with the model, drive new inputs, advance the model
  task automatic step(input bit v, input logic [31:0] a, input logic [31:0] b,
                      input logic [1:0] sel, input logic [1:0] op, input bit ordy,
                      input bit rs, input string tag);
    bit acc;
    @(negedge clk);
    check(out_valid == m_valid, m_valid ? "R9" : "R11", 64'(out_valid), 64'(m_valid));
    if (m_valid && out_valid) check(out_result == m_res, m_tag, 64'(out_result), 64'(m_res));
    in_valid = v; in_rs1 = a; in_rs2 = b; in_bsel = sel; in_op = op; out_ready = ordy; rst = rs;
    #0.5;
    if (!rs) check(in_ready == (!m_valid || ordy), "R10", 64'(in_ready), 64'(!m_valid || ordy));
    acc = v && (!m_valid || ordy);
    if (rs) m_valid = 0;
    else if (acc) begin
      m_valid = 1;
      m_res   = model(a, b, sel, op);
      m_tag   = tag;
    end else if (ordy) m_valid = 0;
  endtask

  function automatic string op_tag(input logic [1:0] op);
    case (op)
      2'b00: return "R2";
      2'b10: return "R3";
      2'b01: return "R4";
      default: return "R5";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R9 watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    build_tables();
    check(fwd_tab[8'h00] == 8'h63, "R2", 64'(fwd_tab[0]), 64'h63);
    check(fwd_tab[8'h53] == 8'hed, "R2", 64'(fwd_tab[8'h53]), 64'hed);
    check(inv_tab[8'h63] == 8'h00, "R3", 64'(inv_tab[8'h63]), 64'h0);

    repeat (3) step(0, 0, 0, 0, 0, 1, 1, "R11");
    step(0, 0, 0, 0, 0, 1, 0, "R11");
    // reset state: out_valid low after reset
    @(negedge clk);
    check(out_valid == 1'b0, "R11", 64'(out_valid), 64'h0);

    // every byte through every variant, lane 0, zero accumulator
    for (int op = 0; op < 4; op++)
      for (int i = 0; i < 256; i++)
        step(1, 32'h0, 32'(i), 2'd0, 2'(op), 1, 0, op_tag(2'(op)));

    // lane select sweep with distinct bytes: R1
    for (int sel = 0; sel < 4; sel++)
      for (int op = 0; op < 4; op++)
        step(1, 32'h0, 32'h53a1_0c7f, 2'(sel), 2'(op), 1, 0, "R1");

    // rotation plus accumulate into random accumulators: R7 and R6
    for (int i = 0; i < 400; i++)
      step(1, $urandom, $urandom, 2'($urandom), 2'(i % 4), 1, 0, (i % 2 == 0) ? "R6" : "R7");

    // accumulators with bit 31 set: R8
    for (int i = 0; i < 64; i++)
      step(1, $urandom | 32'h8000_0000, $urandom, 2'($urandom), 2'($urandom), 1, 0, "R8");

    // random valid and backpressure: R10
    for (int i = 0; i < 2000; i++)
      step(($urandom % 3) != 0, $urandom, $urandom, 2'($urandom), 2'($urandom),
           ($urandom % 2) == 0, 0, "R10");

    // reset while a result is held under backpressure: R11
    step(1, 32'h1234_5678, 32'h9abc_def0, 2'd2, 2'd3, 0, 0, "R11");
    step(0, 0, 0, 0, 0, 0, 0, "R11");
    step(0, 0, 0, 0, 0, 0, 1, "R11");
    step(0, 0, 0, 0, 0, 1, 0, "R11");
    step(0, 0, 0, 0, 0, 1, 0, "R11");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule